// File: doc/BRIEF.md
# SCSI Initiator Command and Interrupt Register Front End

This block is the byte-wide register front end of a simple SCSI initiator. A host reaches it through a plain address, data and strobe bus. The register index is taken from the word-aligned byte address. Every host write lands in a write bank. Every host read returns a separate read bank, which holds the status, interrupt and sequence-step registers. The two banks share addresses but never alias.

Writing the command register decodes an opcode. Some opcodes finish at once: flush, chip reset, and the no-effect ones. Others hand off to an outside helper and wait for it:
- Target selection asks an external selection checker whether the chosen target is present.
- The information-transfer, command-complete and message-accepted operations ask an external transfer engine to move data, then wait for its done strobe.

When a waiting command finishes, the block loads a fixed status/interrupt/sequence triple. It also sets bit 0 of DMA control word 0 and raises a registered interrupt line. The host can lower that line only by writing DMA control word 0 with bit 4 clear.

Top module: `scsi_cmd_regs`

## Requirements
- R1: Every host write to any index stores its byte in the write bank. A read of the same index returns the read bank, not the written byte. `xfer_count` is {write index 1, write index 0}. `sel_id` is bits [2:0] of write index 4.
- R2: After reset, the read bank is zero except index 14, which reads 0x04. All DMA control words read zero, and `irq` and `busy` are low.
- R3: The register index is byte address bits [5:2]. Address bits [1:0] have no effect.
- R4: The command register is index 3. Only bits [6:0] of the written byte choose the operation, and bit 7 is ignored.
- R5: Opcode 0x01 (flush) sets read index 6 (sequence step) to 0 and read index 5 (interrupt) to 0x08. Read index 4 is left unchanged, and `irq` does not rise.
- R6: Opcode 0x02 (chip reset) restores the read bank and DMA words to their reset values. It leaves `irq` and the write bank unchanged.
- R7: Opcodes 0x42 and 0x43 pulse `sel_req` for one cycle. On `sel_ack`, the block loads status/interrupt/sequence as follows:
  - 0x91/0x18/0x04 when `sel_present` is high and `sel_id` is 4 or less;
  - 0x80/0x20/0x00 otherwise.
- R8: Opcodes 0x10, 0x11 and 0x12 pulse `xfer_req` for one cycle, and `xfer_op` shows the opcode. On `xfer_done`, read indexes 4/5/6 become:

  | Opcode | Index 4 | Index 5 | Index 6 |
  |---|---|---|---|
  | 0x10 | 0x93 | 0x10 | 0x00 |
  | 0x11 | 0x93 | 0x18 | 0x04 |
  | 0x12 | 0x93 | 0x20 | 0x00 |

- R9: A finishing selection or transfer sets bit 0 of DMA word 0 and drives `irq` high from the next cycle on.
- R10: A host write to DMA word 0 with bit 4 clear lowers `irq`. A write with bit 4 set, or a write to any other word, leaves `irq` unchanged. If a clear and a completion fall in the same cycle, `irq` ends high and word 0 holds the written value with bit 0 set.
- R11: `busy` is high from the accepted command until its acknowledge or done. Command writes while busy are not executed. A `sel_ack` or `xfer_done` that arrives while idle has no effect.
- R12: `bus_rdata` and `dma_rdata` present the addressed register one cycle after the read strobe.
- R13: Opcodes 0x00, 0x03 and 0x1A, and any opcode not listed above, leave the read bank and `irq` unchanged and start no handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Host byte address |
| bus_wr | input | 1 | Host register write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rd | input | 1 | Host register read strobe |
| bus_rdata | output | 8 | Registered read-bank data |
| dma_idx | input | 2 | DMA control word index |
| dma_wr | input | 1 | DMA control word write strobe |
| dma_wdata | input | 32 | DMA control word write data |
| dma_rd | input | 1 | DMA control word read strobe |
| dma_rdata | output | 32 | Registered DMA control word data |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | A selection or transfer is outstanding |
| xfer_count | output | 16 | Transfer length from write bank |
| sel_id | output | 3 | Selected target ID from write bank |
| sel_req | output | 1 | One-cycle request to selection checker |
| sel_ack | input | 1 | Selection checker answer strobe |
| sel_present | input | 1 | Target present, valid with sel_ack |
| xfer_req | output | 1 | One-cycle request to transfer engine |
| xfer_op | output | 7 | Opcode of the pending transfer |
| xfer_done | input | 1 | Transfer engine finished |

## Verification
The bench goes after several corner cases, each tied to a specific failure:
- **Separate banks.** A byte written to index 5 must not be read back. A design that merged the two banks would return it.
- **Target range.** A present target with ID 5 must fail selection. A design that trusted only the checker's answer would report 0x91.
- **Same-cycle clear and set.** A host clear of `irq` lands in the same cycle as a transfer done. A design that let the clear win would lose the interrupt.
- **Busy hold-off.** A flush issued while busy, and stray done and acknowledge strobes, must change nothing. A design without the hold-off would overwrite the interrupt code with 0x08.
- **Opcode masking.** Opcodes with bit 7 set must still decode correctly. Chip reset must keep both `irq` and the write bank.

// File: rtl/scsi_ctl_pkg.sv
package scsi_ctl_pkg;
  localparam int REG_W = 8;

  localparam logic [6:0] OP_NOP      = 7'h00;
  localparam logic [6:0] OP_FLUSH    = 7'h01;
  localparam logic [6:0] OP_CHIPRST  = 7'h02;
  localparam logic [6:0] OP_BUSRST   = 7'h03;
  localparam logic [6:0] OP_XFER     = 7'h10;
  localparam logic [6:0] OP_CMDCPL   = 7'h11;
  localparam logic [6:0] OP_MSGOK    = 7'h12;
  localparam logic [6:0] OP_ATN      = 7'h1A;
  localparam logic [6:0] OP_SEL      = 7'h42;
  localparam logic [6:0] OP_SELSTOP  = 7'h43;

  localparam int IX_CNT_LO = 0;
  localparam int IX_CNT_HI = 1;
  localparam int IX_CMD    = 3;
  localparam int IX_STAT   = 4;
  localparam int IX_INTR   = 5;
  localparam int IX_SEQ    = 6;
  localparam int IX_REV    = 14;

  localparam logic [REG_W-1:0] REV_CODE = 8'h04;

  localparam logic [REG_W-1:0] ST_PEND   = 8'h80;
  localparam logic [REG_W-1:0] ST_TCNT   = 8'h10;
  localparam logic [REG_W-1:0] PH_DIN    = 8'h01;
  localparam logic [REG_W-1:0] PH_STATUS = 8'h03;
  localparam logic [REG_W-1:0] IN_FDONE  = 8'h08;
  localparam logic [REG_W-1:0] IN_BSVC   = 8'h10;
  localparam logic [REG_W-1:0] IN_DISC   = 8'h20;
  localparam logic [REG_W-1:0] SQ_CMDOK  = 8'h04;

  typedef enum logic [1:0] {CS_IDLE, CS_SEL, CS_XFER} ctl_state_t;

  typedef struct packed {
    logic [REG_W-1:0] stat;
    logic [REG_W-1:0] intr;
    logic [REG_W-1:0] seq;
  } triple_t;
endpackage

// File: rtl/scsi_wbank.sv
module scsi_wbank
  import scsi_ctl_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wr_data,
  output logic [15:0]      count,
  output logic [2:0]       target
);
  logic [REG_W-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) mem[i] <= '0;
      else if (wr_en && wr_idx == IDX_W'(i)) mem[i] <= wr_data;
    end
  end

  logic unused_tgt_hi;
  assign unused_tgt_hi = ^mem[IX_STAT][REG_W-1:3];
  assign count  = {mem[IX_CNT_HI], mem[IX_CNT_LO]};
  assign target = mem[IX_STAT][2:0];
endmodule

// File: rtl/scsi_rbank.sv
module scsi_rbank
  import scsi_ctl_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             flush,
  input  logic             upd,
  input  triple_t          upd_val,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0] rd_data
);
  logic [REG_W-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    localparam logic [REG_W-1:0] INIT = (i == IX_REV) ? REV_CODE : '0;
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        mem[i] <= INIT;
      end else if (upd) begin
        if (i == IX_STAT) mem[i] <= upd_val.stat;
        else if (i == IX_INTR) mem[i] <= upd_val.intr;
        else if (i == IX_SEQ) mem[i] <= upd_val.seq;
      end else if (flush) begin
        if (i == IX_INTR) mem[i] <= IN_FDONE;
        else if (i == IX_SEQ) mem[i] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/scsi_dma_irq.sv
module scsi_dma_irq #(
  parameter int DMA_WORDS = 4,
  parameter int DMA_W     = 32,
  parameter int IRQ_BIT   = 4,
  localparam int DIDX_W = $clog2(DMA_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [DIDX_W-1:0] wr_idx,
  input  logic [DMA_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [DIDX_W-1:0] rd_idx,
  output logic [DMA_W-1:0]  rd_data,
  input  logic              complete,
  output logic              irq
);
  logic [DMA_W-1:0] word [DMA_WORDS];
  logic             host_clr;

  for (genvar i = 0; i < DMA_WORDS; i++) begin : g_word
    logic             hit;
    logic [DMA_W-1:0] base;
    assign hit  = wr_en && wr_idx == DIDX_W'(i);
    assign base = hit ? wr_data : word[i];
    always_ff @(posedge clk) begin
      if (rst || clr) word[i] <= '0;
      else if (i == 0) word[i] <= base | DMA_W'(complete);
      else word[i] <= base;
    end
  end

  assign host_clr = wr_en && wr_idx == '0 && !wr_data[IRQ_BIT];

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else if (complete) irq <= 1'b1;
    else if (host_clr) irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= word[rd_idx];
  end
endmodule

// File: rtl/scsi_cmd_ctl.sv
module scsi_cmd_ctl
  import scsi_ctl_pkg::*;
#(
  parameter int MAX_TARGET = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cmd_wr,
  input  logic [6:0] cmd_op,
  input  logic [2:0] tgt_id,
  input  logic     sel_ack,
  input  logic     sel_present,
  input  logic     xfer_done,
  output logic     busy,
  output logic     sel_req,
  output logic     xfer_req,
  output logic [6:0] xfer_op,
  output logic     flush,
  output logic     chip_clr,
  output logic     upd,
  output triple_t  upd_val
);
  ctl_state_t state;
  logic       accept, is_sel, is_xfer, tgt_ok;

  assign accept  = cmd_wr && state == CS_IDLE;
  assign is_sel  = cmd_op == OP_SEL || cmd_op == OP_SELSTOP;
  assign is_xfer = cmd_op == OP_XFER || cmd_op == OP_CMDCPL || cmd_op == OP_MSGOK;
  assign flush    = accept && cmd_op == OP_FLUSH;
  assign chip_clr = accept && cmd_op == OP_CHIPRST;
  assign tgt_ok   = sel_present && (int'(tgt_id) <= MAX_TARGET);

  always_comb begin
    upd     = 1'b0;
    upd_val = '0;
    if (state == CS_SEL && sel_ack) begin
      upd = 1'b1;
      if (tgt_ok) upd_val = '{stat: ST_PEND | ST_TCNT | PH_DIN, intr: IN_BSVC | IN_FDONE, seq: SQ_CMDOK};
      else        upd_val = '{stat: ST_PEND, intr: IN_DISC, seq: '0};
    end else if (state == CS_XFER && xfer_done) begin
      upd = 1'b1;
      upd_val.stat = ST_PEND | ST_TCNT | PH_STATUS;
      case (xfer_op)
        OP_XFER:   begin upd_val.intr = IN_BSVC;            upd_val.seq = '0;        end
        OP_CMDCPL: begin upd_val.intr = IN_BSVC | IN_FDONE; upd_val.seq = SQ_CMDOK;  end
        default:   begin upd_val.intr = IN_DISC;            upd_val.seq = '0;        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= CS_IDLE;
      sel_req  <= 1'b0;
      xfer_req <= 1'b0;
      xfer_op  <= '0;
    end else begin
      sel_req  <= accept && is_sel;
      xfer_req <= accept && is_xfer;
      if (accept && is_sel) state <= CS_SEL;
      else if (accept && is_xfer) begin
        state   <= CS_XFER;
        xfer_op <= cmd_op;
      end else if (upd) state <= CS_IDLE;
    end
  end

  assign busy = state != CS_IDLE;
endmodule

// File: rtl/scsi_cmd_regs.sv
module scsi_cmd_regs
  import scsi_ctl_pkg::*;
#(
  parameter int NREG       = 16,
  parameter int DMA_WORDS  = 4,
  parameter int DMA_W      = 32,
  parameter int MAX_TARGET = 4,
  localparam int IDX_W  = $clog2(NREG),
  localparam int ADDR_W = IDX_W + 2,
  localparam int DIDX_W = $clog2(DMA_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [DIDX_W-1:0] dma_idx,
  input  logic              dma_wr,
  input  logic [DMA_W-1:0]  dma_wdata,
  input  logic              dma_rd,
  output logic [DMA_W-1:0]  dma_rdata,
  output logic              irq,
  output logic              busy,
  output logic [15:0]       xfer_count,
  output logic [2:0]        sel_id,
  output logic              sel_req,
  input  logic              sel_ack,
  input  logic              sel_present,
  output logic              xfer_req,
  output logic [6:0]        xfer_op,
  input  logic              xfer_done
);
  logic [IDX_W-1:0] reg_idx;
  logic             unused_byte_lane;
  logic             cmd_wr, flush, chip_clr, upd;
  triple_t          upd_val;

  assign reg_idx          = bus_addr[ADDR_W-1:2];
  assign unused_byte_lane = ^bus_addr[1:0];
  assign cmd_wr           = bus_wr && reg_idx == IDX_W'(IX_CMD);

  scsi_wbank #(.NREG(NREG)) u_wbank (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .wr_idx(reg_idx), .wr_data(bus_wdata),
    .count(xfer_count), .target(sel_id)
  );

  scsi_cmd_ctl #(.MAX_TARGET(MAX_TARGET)) u_ctl (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_op(bus_wdata[6:0]), .tgt_id(sel_id),
    .sel_ack(sel_ack), .sel_present(sel_present), .xfer_done(xfer_done),
    .busy(busy), .sel_req(sel_req), .xfer_req(xfer_req), .xfer_op(xfer_op),
    .flush(flush), .chip_clr(chip_clr), .upd(upd), .upd_val(upd_val)
  );

  scsi_rbank #(.NREG(NREG)) u_rbank (
    .clk(clk), .rst(rst), .clr(chip_clr), .flush(flush), .upd(upd), .upd_val(upd_val),
    .rd_en(bus_rd), .rd_idx(reg_idx), .rd_data(bus_rdata)
  );

  scsi_dma_irq #(.DMA_WORDS(DMA_WORDS), .DMA_W(DMA_W)) u_dma (
    .clk(clk), .rst(rst), .clr(chip_clr), .wr_en(dma_wr), .wr_idx(dma_idx),
    .wr_data(dma_wdata), .rd_en(dma_rd), .rd_idx(dma_idx), .rd_data(dma_rdata),
    .complete(upd), .irq(irq)
  );
endmodule

// File: rtl/scsi_cmd_regs_chk.sv
module scsi_cmd_regs_chk #(
  parameter int IDX_W  = 4,
  parameter int DIDX_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [IDX_W-1:0]  reg_idx,
  input logic              bus_wr,
  input logic [DIDX_W-1:0] dma_idx,
  input logic              dma_wr,
  input logic              dma_keep,
  input logic              irq,
  input logic              busy,
  input logic              sel_req,
  input logic              sel_ack,
  input logic              xfer_req,
  input logic              xfer_done
);
  assert_sel_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    sel_req |=> !sel_req);

  assert_xfer_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    xfer_req |=> !xfer_req);

  assert_req_while_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (sel_req || xfer_req) |-> busy);

  assert_single_req_R11: assert property (@(posedge clk) disable iff (rst)
    !(sel_req && xfer_req));

  assert_busy_from_cmd_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_wr && reg_idx == IDX_W'(3)));

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(busy && (sel_ack || xfer_done)));

  assert_irq_fall_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(dma_wr && dma_idx == '0 && !dma_keep));
endmodule

bind scsi_cmd_regs scsi_cmd_regs_chk #(.IDX_W(IDX_W), .DIDX_W(DIDX_W)) u_chk (
  .clk(clk), .rst(rst), .reg_idx(bus_addr[ADDR_W-1:2]), .bus_wr(bus_wr),
  .dma_idx(dma_idx), .dma_wr(dma_wr), .dma_keep(dma_wdata[4]), .irq(irq),
  .busy(busy), .sel_req(sel_req), .sel_ack(sel_ack), .xfer_req(xfer_req),
  .xfer_done(xfer_done)
);

// File: tb/test_scsi_cmd_regs.sv
`timescale 1ns/1ps
module test_scsi_cmd_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [1:0]  dma_idx = '0;
  logic        dma_wr = 1'b0, dma_rd = 1'b0;
  logic [31:0] dma_wdata = '0;
  logic [31:0] dma_rdata;
  logic        irq, busy, sel_req, xfer_req;
  logic        sel_ack = 1'b0, sel_present = 1'b0, xfer_done = 1'b0;
  logic [15:0] xfer_count;
  logic [2:0]  sel_id;
  logic [6:0]  xfer_op;

  always #2.5 clk = ~clk;

  scsi_cmd_regs i_scsi_cmd_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .dma_idx(dma_idx), .dma_wr(dma_wr),
    .dma_wdata(dma_wdata), .dma_rd(dma_rd), .dma_rdata(dma_rdata), .irq(irq),
    .busy(busy), .xfer_count(xfer_count), .sel_id(sel_id), .sel_req(sel_req),
    .sel_ack(sel_ack), .sel_present(sel_present), .xfer_req(xfer_req),
    .xfer_op(xfer_op), .xfer_done(xfer_done)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R2";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0]  m_rb [16];
  logic [7:0]  m_wb [16];
  logic [31:0] m_dw [4];
  logic        m_irq, m_sreq, m_xreq;
  logic [6:0]  m_pop;
  logic [7:0]  m_rd;
  logic [31:0] m_drd;
  int          m_st, ix, dx, old_st;
  logic        m_done, m_crst;
  logic [7:0]  ts, ti, tq;
  logic [6:0]  op;

  always @(posedge clk) begin
    ix = int'(bus_addr[5:2]);
    dx = int'(dma_idx);
    if (rst) begin
      for (int i = 0; i < 16; i++) begin m_rb[i] = 8'h00; m_wb[i] = 8'h00; end
      m_rb[14] = 8'h04;
      for (int i = 0; i < 4; i++) m_dw[i] = 32'h0;
      m_irq = 0; m_st = 0; m_pop = 0; m_sreq = 0; m_xreq = 0; m_rd = 0; m_drd = 0;
    end else begin
      if (bus_rd) m_rd = m_rb[ix];
      if (dma_rd) m_drd = m_dw[dx];
      m_sreq = 0; m_xreq = 0; m_done = 0; m_crst = 0;
      old_st = m_st;
      if (old_st == 1 && sel_ack) begin
        m_done = 1; m_st = 0;
        if (sel_present && m_wb[4][2:0] <= 3'd4) begin ts = 8'h91; ti = 8'h18; tq = 8'h04; end
        else begin ts = 8'h80; ti = 8'h20; tq = 8'h00; end
      end
      if (old_st == 2 && xfer_done) begin
        m_done = 1; m_st = 0; ts = 8'h93;
        if (m_pop == 7'h10) begin ti = 8'h10; tq = 8'h00; end
        else if (m_pop == 7'h11) begin ti = 8'h18; tq = 8'h04; end
        else begin ti = 8'h20; tq = 8'h00; end
      end
      if (m_done) begin m_rb[4] = ts; m_rb[5] = ti; m_rb[6] = tq; end
      if (bus_wr) begin
        if (ix == 3 && old_st == 0) begin
          op = bus_wdata[6:0];
          case (op)
            7'h01: begin m_rb[6] = 8'h00; m_rb[5] = 8'h08; end
            7'h02: m_crst = 1;
            7'h10, 7'h11, 7'h12: begin m_st = 2; m_pop = op; m_xreq = 1; end
            7'h42, 7'h43: begin m_st = 1; m_sreq = 1; end
            default: ;
          endcase
        end
        m_wb[ix] = bus_wdata;
      end
      if (dma_wr) begin
        m_dw[dx] = dma_wdata;
        if (dx == 0 && !dma_wdata[4]) m_irq = 0;
      end
      if (m_crst) begin
        for (int i = 0; i < 16; i++) m_rb[i] = 8'h00;
        m_rb[14] = 8'h04;
        for (int i = 0; i < 4; i++) m_dw[i] = 32'h0;
      end
      if (m_done) begin m_dw[0] = m_dw[0] | 32'h1; m_irq = 1; end
    end
  end

  always @(negedge clk) begin
    chk({cur_req, " model irq"}, {31'h0, irq}, {31'h0, m_irq});
    chk({cur_req, " model busy"}, {31'h0, busy}, {31'h0, m_st != 0});
    chk({cur_req, " model sel_req"}, {31'h0, sel_req}, {31'h0, m_sreq});
    chk({cur_req, " model xfer_req"}, {31'h0, xfer_req}, {31'h0, m_xreq});
    chk({cur_req, " model xfer_op"}, {25'h0, xfer_op}, {25'h0, m_pop});
    chk({cur_req, " model bus_rdata"}, {24'h0, bus_rdata}, {24'h0, m_rd});
    chk({cur_req, " model dma_rdata"}, dma_rdata, m_drd);
    chk({cur_req, " model xfer_count"}, {16'h0, xfer_count}, {16'h0, m_wb[1], m_wb[0]});
    chk({cur_req, " model sel_id"}, {29'h0, sel_id}, {29'h0, m_wb[4][2:0]});
  end

  task automatic wreg(input logic [5:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rreg(input logic [5:0] a, input logic [7:0] e, input string tag);
    bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
    chk(tag, {24'h0, bus_rdata}, {24'h0, e});
  endtask
  task automatic dwr(input logic [1:0] i, input logic [31:0] d);
    dma_idx = i; dma_wdata = d; dma_wr = 1;
    @(negedge clk); dma_wr = 0;
  endtask
  task automatic drd(input logic [1:0] i, input logic [31:0] e, input string tag);
    dma_idx = i; dma_rd = 1;
    @(negedge clk); dma_rd = 0;
    chk(tag, dma_rdata, e);
  endtask
  task automatic ack(input logic p);
    sel_ack = 1; sel_present = p;
    @(negedge clk); sel_ack = 0; sel_present = 0;
  endtask
  task automatic done();
    xfer_done = 1;
    @(negedge clk); xfer_done = 0;
  endtask
  task automatic triple(input logic [7:0] s, input logic [7:0] n, input logic [7:0] q,
                        input string tag);
    rreg(6'h10, s, {tag, " status"});
    rreg(6'h14, n, {tag, " intr"});
    rreg(6'h18, q, {tag, " seq"});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R2";
    rreg(6'h38, 8'h04, "R2/R12 rev id");
    rreg(6'h10, 8'h00, "R2/R12 status");
    drd(2'd0, 32'h0, "R2/R12 dma word0");
    chk("R2 irq", {31'h0, irq}, 32'h0);
    chk("R2 busy", {31'h0, busy}, 32'h0);

    cur_req = "R3";
    wreg(6'h01, 8'h34);
    wreg(6'h06, 8'h12);
    chk("R3 xfer_count", {16'h0, xfer_count}, 32'h1234);
    cur_req = "R1";
    wreg(6'h13, 8'h0A);
    chk("R1 sel_id", {29'h0, sel_id}, 32'h2);
    wreg(6'h14, 8'h55);
    rreg(6'h14, 8'h00, "R1 read bank separate");

    cur_req = "R5";
    wreg(6'h0C, 8'h01);
    triple(8'h00, 8'h08, 8'h00, "R5 flush");
    chk("R5 irq", {31'h0, irq}, 32'h0);

    cur_req = "R7";
    wreg(6'h0C, 8'h42);
    chk("R7 sel_req", {31'h0, sel_req}, 32'h1);
    chk("R11 busy", {31'h0, busy}, 32'h1);
    ack(1'b1);
    chk("R9 irq", {31'h0, irq}, 32'h1);
    triple(8'h91, 8'h18, 8'h04, "R7 sel ok");
    drd(2'd0, 32'h1, "R9 dma bit0");

    cur_req = "R10";
    dwr(2'd0, 32'h10);
    chk("R10 keep bit4", {31'h0, irq}, 32'h1);
    drd(2'd0, 32'h10, "R10 word0");
    dwr(2'd1, 32'h0);
    chk("R10 other word", {31'h0, irq}, 32'h1);
    dwr(2'd0, 32'h01);
    chk("R10 clear", {31'h0, irq}, 32'h0);

    cur_req = "R7";
    wreg(6'h10, 8'h05);
    wreg(6'h0C, 8'h42);
    ack(1'b1);
    triple(8'h80, 8'h20, 8'h00, "R7 id above 4");

    cur_req = "R8";
    wreg(6'h0C, 8'h10);
    chk("R8 xfer_req", {31'h0, xfer_req}, 32'h1);
    chk("R8 xfer_op", {25'h0, xfer_op}, 32'h10);
    cur_req = "R11";
    wreg(6'h0C, 8'h01);
    rreg(6'h14, 8'h20, "R11 held off");
    done();
    triple(8'h93, 8'h10, 8'h00, "R8 op 10");
    done();
    ack(1'b1);
    rreg(6'h14, 8'h10, "R11 stray strobes");
    chk("R11 idle", {31'h0, busy}, 32'h0);

    cur_req = "R10";
    dwr(2'd0, 32'h0);
    wreg(6'h0C, 8'h11);
    xfer_done = 1; dma_idx = 2'd0; dma_wdata = 32'h0; dma_wr = 1;
    @(negedge clk); xfer_done = 0; dma_wr = 0;
    chk("R10 set wins", {31'h0, irq}, 32'h1);
    drd(2'd0, 32'h1, "R10 set wins word0");
    triple(8'h93, 8'h18, 8'h04, "R8 op 11");

    cur_req = "R8";
    wreg(6'h0C, 8'h12);
    done();
    triple(8'h93, 8'h20, 8'h00, "R8 op 12");

    cur_req = "R4";
    wreg(6'h10, 8'h03);
    wreg(6'h0C, 8'hC3);
    chk("R4 bit7 ignored", {31'h0, sel_req}, 32'h1);
    ack(1'b0);
    triple(8'h80, 8'h20, 8'h00, "R7 absent");

    cur_req = "R13";
    wreg(6'h0C, 8'h01);
    wreg(6'h0C, 8'h7F);
    wreg(6'h0C, 8'h00);
    wreg(6'h0C, 8'h03);
    wreg(6'h0C, 8'h1A);
    wreg(6'h0C, 8'h44);
    triple(8'h80, 8'h08, 8'h00, "R13 no change");
    chk("R13 irq", {31'h0, irq}, 32'h1);
    chk("R13 busy", {31'h0, busy}, 32'h0);

    cur_req = "R6";
    wreg(6'h0C, 8'h82);
    triple(8'h00, 8'h00, 8'h00, "R6 chip reset");
    rreg(6'h38, 8'h04, "R6 rev id");
    drd(2'd0, 32'h0, "R6 dma word0");
    chk("R6 irq kept", {31'h0, irq}, 32'h1);
    chk("R6 write bank kept", {16'h0, xfer_count}, 32'h1234);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act running exp finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule